// File: doc/BRIEF.md
# Code Bag Fetch Engine

This block takes a packed descriptor and streams a run of consecutive words out of a synchronous on-chip RAM, in address order, to an instruction output port. The descriptor carries a start address in its upper field and a word count in its low field. The block fetches with a fixed stride of one, using its own cursor. It stops when the count is used up, and only then acknowledges the descriptor.

Both the descriptor input and the word output use a four-phase request/acknowledge handshake. A new output word is fetched only while the output port is fully idle, that is, with its request and its acknowledge both low. The RAM has one cycle of read latency, and the output request is raised in the same clock edge that delivers the read data. A fill port writes words into the RAM before any fetch.

Top module: `cbag_fetch`

## Requirements
- R1: While `rst_n` is low, `out_req` and `desc_ack` are low.
- R2: The descriptor packs the word count in bits 5..0 and the start address in bits 36..6. Only the low `RAM_AW` (default 8) address bits select a RAM word.
- R3: A descriptor with base B and count N delivers exactly N words, read from RAM addresses (B+k) mod 2^RAM_AW for k = 0..N-1, in that order, and no further word.
- R4: `out_req` rises only when `out_ack` was low in the previous cycle. The first word's request is high after the second rising edge that samples `desc_req` high, and not after the first.
- R5: Once `out_req` is high and `out_ack` is low, `out_req` stays high and `out_word` stays stable. `out_req` falls at the first rising edge that samples `out_ack` high.
- R6: While `out_ack` stays high after `out_req` has fallen, no new word is requested. The next word's request is high after the first rising edge that samples `out_ack` low.
- R7: `desc_ack` rises only after the last word of the descriptor has been issued, and no read is issued while it is high. A count of zero gives `desc_ack` with no words.
- R8: `desc_ack` stays high while `desc_req` is high and falls at the first rising edge that samples `desc_req` low. The next descriptor starts from its own base.
- R9: A count of 63, the largest count, delivers all 63 words.
- R10: A fill-port write with `fill_en` high stores `fill_data` at `fill_addr`, and a later fetch of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | RAM fill write enable |
| fill_addr | input | RAM_AW | RAM fill address |
| fill_data | input | DATA_W | RAM fill data |
| desc_req | input | 1 | Descriptor request |
| desc_word | input | ADDR_W+CNT_W | Descriptor: address in the upper field, count in the low field |
| desc_ack | output | 1 | Descriptor done acknowledge |
| out_req | output | 1 | Output word request |
| out_word | output | DATA_W | Output word |
| out_ack | input | 1 | Output word acknowledge |

## Verification
The first word is due two rising edges after `desc_req` is sampled high. `out_req` falls one edge after `out_ack` is seen high. The next word is due one edge after `out_ack` is seen low. `desc_ack` falls one edge after `desc_req` is withdrawn. The bench drives every input at a falling edge and samples every output at a later falling edge. It steps a directed sequence edge by edge so that each of these latencies is checked in its exact cycle. The table-driven runs add random stalls on the consumer side. They check each word's value when it is accepted. They also confirm that `desc_ack` never appears before the last word is on the port.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_DONE = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/cbag_ram.sv
module cbag_ram #(
  parameter int DATA_W = 37,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= store[rd_addr];
    end
  end
endmodule

// File: rtl/cbag_seq.sv
module cbag_seq
  import cbag_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 6,
  parameter int RAM_AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    desc_req,
  input  logic [ADDR_W+CNT_W-1:0] desc_word,
  output logic                    desc_ack,
  input  logic                    port_idle,
  output logic                    rd_en,
  output logic [RAM_AW-1:0]       rd_addr
);
  localparam int DESC_W = ADDR_W + CNT_W;

  fetch_state_e      state_q, state_d;
  logic [DESC_W-1:0] desc_q;
  logic              desc_ld;
  logic [CNT_W-1:0]  cursor_q, cursor_d;
  logic              cursor_en;
  logic [CNT_W-1:0]  size_q;
  logic [RAM_AW-1:0] base_q;
  logic              last_done;

  assign size_q    = desc_q[CNT_W-1:0];
  assign base_q    = RAM_AW'(desc_q[DESC_W-1:CNT_W]);
  assign last_done = (cursor_q == size_q);

  // next-state and cursor logic
  always_comb begin
    state_d   = state_q;
    cursor_d  = cursor_q;
    cursor_en = 1'b0;
    desc_ld   = 1'b0;
    rd_en     = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (desc_req) begin
          desc_ld   = 1'b1;
          cursor_d  = '0;
          cursor_en = 1'b1;
          state_d   = FS_RUN;
        end
      end
      FS_RUN: begin
        if (last_done) begin
          cursor_d  = '0;
          cursor_en = 1'b1;
          state_d   = FS_DONE;
        end else if (port_idle) begin
          rd_en     = 1'b1;
          cursor_d  = cursor_q + 1'b1;
          cursor_en = 1'b1;
        end
      end
      FS_DONE: begin
        if (!desc_req) begin
          state_d = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  assign rd_addr  = base_q + RAM_AW'(cursor_q);
  assign desc_ack = (state_q == FS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      cursor_q <= '0;
      desc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cursor_en) begin
        cursor_q <= cursor_d;
      end
      if (desc_ld) begin
        desc_q <= desc_word;
      end
    end
  end

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ack && desc_req |=> desc_ack); // R8
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ack && !desc_req |=> !desc_ack); // R8
  AST_NO_READ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ack |-> !rd_en); // R7
  AST_CURSOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_RUN) |-> cursor_q <= size_q); // R3
endmodule

// File: rtl/cbag_outport.sv
module cbag_outport #(
  parameter int DATA_W = 37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              out_ack,
  output logic              out_req,
  output logic [DATA_W-1:0] out_word,
  output logic              port_idle
);
  logic req_d;

  always_comb begin
    req_d = out_req;
    if (rd_en) begin
      req_d = 1'b1;
    end else if (out_req && out_ack) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_req <= 1'b0;
    end else begin
      out_req <= req_d;
    end
  end

  // RAM read register holds the word until the next read, which waits for idle
  assign out_word  = rd_data;
  assign port_idle = !out_req && !out_ack;

  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(!out_ack)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req); // R5
  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> $stable(out_word)); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && out_ack |=> !out_req); // R5
endmodule

// File: rtl/cbag_fetch.sv
module cbag_fetch #(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 6,
  parameter int RAM_AW = 8,
  parameter int DATA_W = 37
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_en,
  input  logic [RAM_AW-1:0]       fill_addr,
  input  logic [DATA_W-1:0]       fill_data,
  input  logic                    desc_req,
  input  logic [ADDR_W+CNT_W-1:0] desc_word,
  output logic                    desc_ack,
  output logic                    out_req,
  output logic [DATA_W-1:0]       out_word,
  input  logic                    out_ack
);
  logic              rd_en;
  logic [RAM_AW-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              port_idle;

  cbag_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .RAM_AW (RAM_AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_req  (desc_req),
    .desc_word (desc_word),
    .desc_ack  (desc_ack),
    .port_idle (port_idle),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
  );

  cbag_ram #(
    .DATA_W (DATA_W),
    .AW     (RAM_AW)
  ) u_ram (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_addr (fill_addr),
    .wr_data (fill_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cbag_outport #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .out_ack   (out_ack),
    .out_req   (out_req),
    .out_word  (out_word),
    .port_idle (port_idle)
  );

  AST_ACK_NEEDS_IDLE_OR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_ack) |-> !rd_en); // R7
endmodule

// File: tb/tb_cbag_fetch.sv
module tb_cbag_fetch;
  localparam int DEPTH = 256;
  localparam int NTAB  = 6;

  logic        clk;
  logic        rst_n;
  logic        fill_en;
  logic [7:0]  fill_addr;
  logic [36:0] fill_data;
  logic        desc_req;
  logic [36:0] desc_word;
  logic        desc_ack;
  logic        out_req;
  logic [36:0] out_word;
  logic        out_ack;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  cbag_fetch dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_en),
    .fill_addr (fill_addr),
    .fill_data (fill_data),
    .desc_req  (desc_req),
    .desc_word (desc_word),
    .desc_ack  (desc_ack),
    .out_req   (out_req),
    .out_word  (out_word),
    .out_ack   (out_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // descriptor table: {base[30:0], count[5:0]}
  localparam logic [36:0] DESC_TAB [NTAB] = '{
    {31'd10,         6'd5},
    {31'd0,          6'd0},
    {31'd200,        6'd63},
    {31'd250,        6'd12},
    {31'h7FFF_FF00,  6'd3},
    {31'd77,         6'd1}
  };

  function automatic logic [36:0] pat(input int a);
    logic [7:0] lo;
    lo = 8'(a);
    return {lo ^ 8'h5A, 29'(a * 977 + 3)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_desc(input logic [30:0] base, input logic [5:0] size,
                          input int maxstall);
    int got;
    int stall;
    int early;
    logic [7:0] a;
    got   = 0;
    stall = 0;
    early = 0;
    @(negedge clk);
    desc_word = {base, size};
    desc_req  = 1'b1;
    do begin
      @(negedge clk);
      if (desc_ack && got < int'(size) - 1) early = 1;
      if (out_req && !out_ack) begin
        if (stall > 0) begin
          stall--;
        end else begin
          a = 8'(base + 31'(got));
          chk(out_word === pat(int'(a)), "R3 word order", 64'(out_word), 64'(pat(int'(a))));
          got++;
          out_ack = 1'b1;
          stall = $urandom_range(0, maxstall);
        end
      end else if (!out_req && out_ack) begin
        out_ack = 1'b0;
      end
    end while (!(desc_ack && !out_req && !out_ack));
    if (size == 6'd63)
      chk(got == 63, "R9 full count", 64'(got), 64'd63);
    else
      chk(got == int'(size), "R3 word count", 64'(got), 64'(size));
    chk(early == 0, "R7 ack before last word", 64'(early), 64'd0);
    desc_req = 1'b0;
    @(negedge clk);
    chk(desc_ack == 1'b0, "R8 ack release", 64'(desc_ack), 64'd0);
    @(negedge clk);
    chk(out_req == 1'b0, "R3 no extra word", 64'(out_req), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    fill_en   = 1'b0;
    fill_addr = '0;
    fill_data = '0;
    desc_req  = 1'b0;
    desc_word = '0;
    out_ack   = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_req == 1'b0, "R1 out_req in reset", 64'(out_req), 64'd0);
    chk(desc_ack == 1'b0, "R1 desc_ack in reset", 64'(desc_ack), 64'd0);
    rst_n = 1'b1;

    // preload through the fill port
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      fill_en   = 1'b1;
      fill_addr = 8'(i);
      fill_data = pat(i);
    end
    @(negedge clk);
    fill_en = 1'b0;

    // table-driven runs with random consumer stalls (R2 address field)
    for (int t = 0; t < NTAB; t++) begin
      run_desc(DESC_TAB[t][36:6], DESC_TAB[t][5:0], (t % 3) + 1);
    end

    // directed timing: base 100, count 2, stepped edge by edge
    @(negedge clk);
    desc_word = {31'd100, 6'd2};
    desc_req  = 1'b1;
    @(negedge clk);
    chk(out_req == 1'b0, "R4 no request after one edge", 64'(out_req), 64'd0);
    @(negedge clk);
    chk(out_req == 1'b1, "R4 request after two edges", 64'(out_req), 64'd1);
    chk(out_word == pat(100), "R2 first word", 64'(out_word), 64'(pat(100)));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_req == 1'b1, "R5 request held", 64'(out_req), 64'd1);
      chk(out_word == pat(100), "R5 word stable", 64'(out_word), 64'(pat(100)));
    end
    out_ack = 1'b1;
    @(negedge clk);
    chk(out_req == 1'b0, "R5 request drop", 64'(out_req), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_req == 1'b0, "R6 wait while ack high", 64'(out_req), 64'd0);
    end
    out_ack = 1'b0;
    @(negedge clk);
    chk(out_req == 1'b1, "R6 next request", 64'(out_req), 64'd1);
    chk(out_word == pat(101), "R3 second word", 64'(out_word), 64'(pat(101)));
    @(negedge clk);
    chk(desc_ack == 1'b1, "R7 ack after last issue", 64'(desc_ack), 64'd1);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(desc_ack == 1'b1, "R8 ack held", 64'(desc_ack), 64'd1);
      chk(out_req == 1'b0, "R7 no read while acked", 64'(out_req), 64'd0);
    end
    desc_req = 1'b0;
    @(negedge clk);
    chk(desc_ack == 1'b0, "R8 ack falls", 64'(desc_ack), 64'd0);

    // zero count: ack with no words
    @(negedge clk);
    desc_word = {31'd5, 6'd0};
    desc_req  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(desc_ack == 1'b1, "R7 zero count ack", 64'(desc_ack), 64'd1);
    chk(out_req == 1'b0, "R7 zero count no word", 64'(out_req), 64'd0);
    desc_req = 1'b0;
    @(negedge clk);

    // fill overwrite then fetch it, cursor starts from the new base
    fill_en   = 1'b1;
    fill_addr = 8'd40;
    fill_data = 37'h1_ABCD_E012;
    @(negedge clk);
    fill_en = 1'b0;
    desc_word = {31'd40, 6'd1};
    desc_req  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_req == 1'b1, "R10 fill word request", 64'(out_req), 64'd1);
    chk(out_word == 37'h1_ABCD_E012, "R10 fill word value", 64'(out_word), 64'h1_ABCD_E012);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    @(negedge clk);
    chk(desc_ack == 1'b1, "R8 new base done", 64'(desc_ack), 64'd1);
    desc_req = 1'b0;
    @(negedge clk);

    // one more table entry after the directed part, checks a fresh start
    run_desc(31'd3, 6'd4, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule